// File: doc/BRIEF.md
# Dual Timer: Auto-Reload Down Counter and Wide Free-Running Counter

This block holds two independent counters behind one small register bus. The first is a 16-bit down counter that generates the periodic interrupt. It decrements once per tick of a selected clock-enable strobe. When it passes zero it either reloads from a programmed start value or wraps to all ones, and in both cases it raises an interrupt request. The request stays high until software writes to a clear register. The second is a 40-bit up counter that runs on the faster strobe. It serves as a timebase and never interrupts. Software starts it and stops it through one bit of its upper register.

Both tick rates arrive as single-cycle enable strobes on the block clock. Typical rates are near 508 kHz for the slow strobe and 983.04 kHz for the fast one. A register read has one cycle of latency. Software normally writes the start value, then writes a configuration with the run bit clear, and then writes the same configuration with the run bit set. That final write copies the start value into the counter.

Top module: `tmr_pair`

## Requirements
- R1: After reset every readable register returns zero: start value, count, control, free-running low and high words. `irq` is low.
- R2: Word addresses are 0 start value, 1 count, 2 control, 3 clear, 4 free low, 5 free high. A control write that sets bit 7 while the run flag is 0 copies the start value into the count. While the run flag is 0 the count holds, including across strobes and start-value writes.
- R3: While running, the count decrements by one per strobe. Control bit 3 = 1 selects `slow_tick` and bit 3 = 0 selects `fast_tick`. The strobe that is not selected has no effect.
- R4: When control bit 6 = 1, a strobe that arrives at count 0 reloads the start value and raises `irq`. A start value of N-1 therefore gives one underflow every N strobes.
- R5: When control bit 6 = 0, a strobe that arrives at count 0 sets the count to 0xFFFF and still raises `irq`.
- R6: `irq` stays high until a write of any data to the clear address. If an underflow occurs in the same cycle as the clear write, the underflow wins and `irq` stays high.
- R7: The control register reads back bits 7, 6 and 3 and returns zero in all other bits. Writes to the count address are ignored.
- R8: A write to the free high address loads the free-running enable from data bit 8. While enabled, the 40-bit counter adds one per `fast_tick`. While disabled, it holds its value.
- R9: The free low address returns counter bits 31:0. The free high address returns counter bits 39:32 in bits 7:0 and the enable in bit 8. The free-running counter never changes `irq`.
- R10: `bus_rdata` updates one cycle after a cycle with `bus_rd` high, showing the register addressed in that cycle. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | Slow clock-enable strobe for the down counter |
| fast_tick | input | 1 | Fast clock-enable strobe for the free-running counter and, optionally, the down counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Down counter underflow interrupt request |

## Verification
The bound checker watches several rules on every cycle. Each underflow sets `irq`, and `irq` rises for no other reason. A clear write with no underflow in the same cycle drops `irq`. A stopped counter holds its count. The value after an underflow is the start value in reload mode and all ones in wrap mode. The free-running counter holds between fast strobes. Some behaviour can only be shown by the bench's scenarios, because it depends on a sequence of bus operations or on a count of strobes: the N-strobe interrupt period, the choice of strobe by the control register, read-back masking, ignored count writes, the layout of the high word, and the one-cycle read latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;

  // Word addresses of the register file
  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD    = 3'd0,
    REG_VALUE   = 3'd1,
    REG_CTRL    = 3'd2,
    REG_CLEAR   = 3'd3,
    REG_FREE_LO = 3'd4,
    REG_FREE_HI = 3'd5
  } reg_sel_e;

  localparam int unsigned CTRL_RUN_BIT  = 7;
  localparam int unsigned CTRL_PER_BIT  = 6;
  localparam int unsigned CTRL_SLOW_BIT = 3;
  localparam int unsigned FREE_EN_BIT   = 8;

  typedef struct packed {
    logic run;
    logic periodic;
    logic slow_sel;
  } ctrl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_reload.sv
module tmr_reload
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  ctrl_t            ctrl,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             uflow,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             tick_sel;

  assign tick_sel = ctrl.slow_sel ? slow_tick : fast_tick;
  assign uflow    = ctrl.run && tick_sel && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = load_val;
    end else if (ctrl.run && tick_sel) begin
      if (cnt_q == '0) cnt_d = ctrl.periodic ? load_val : '1;
      else             cnt_d = cnt_q - ONE;
    end
    irq_d = irq_q;
    if (clr)   irq_d = 1'b0;
    if (uflow) irq_d = 1'b1;  // underflow beats a coincident clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fast_tick,
  input  logic         en_wr,
  input  logic         en_val,
  output logic [W-1:0] cnt,
  output logic         en
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         en_q, en_d;

  always_comb begin
    en_d  = en_wr ? en_val : en_q;
    cnt_d = (en_q && fast_tick) ? cnt_q + ONE : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign cnt = cnt_q;
  assign en  = en_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FREE_W     = 40,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int unsigned HI_W = FREE_W - BUS_W;

  logic              rst_q_n;
  logic              wr_load, wr_ctrl, wr_clear, wr_hi;
  logic              tm_start;
  logic [CNT_W-1:0]  load_q, load_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  tm_cnt;
  logic              tm_uflow;
  logic [FREE_W-1:0] fr_cnt;
  logic              fr_en;
  logic [BUS_W-1:0]  rd_mux;
  logic [BUS_W-1:0]  rdata_q, rdata_d;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  tmr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  // Write decode
  assign wr_load  = bus_wr && (bus_addr == REG_LOAD);
  assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
  assign wr_clear = bus_wr && (bus_addr == REG_CLEAR);
  assign wr_hi    = bus_wr && (bus_addr == REG_FREE_HI);
  assign tm_start = wr_ctrl && bus_wdata[CTRL_RUN_BIT] && !ctrl_q.run;

  always_comb begin
    load_d = wr_load ? bus_wdata[CNT_W-1:0] : load_q;
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.run      = bus_wdata[CTRL_RUN_BIT];
      ctrl_d.periodic = bus_wdata[CTRL_PER_BIT];
      ctrl_d.slow_sel = bus_wdata[CTRL_SLOW_BIT];
    end
  end

  tmr_reload #(.CNT_W(CNT_W)) u_reload (
    .clk(clk), .rst_n(rst_q_n),
    .slow_tick(slow_tick), .fast_tick(fast_tick),
    .ctrl(ctrl_q), .start(tm_start), .load_val(load_q), .clr(wr_clear),
    .cnt(tm_cnt), .uflow(tm_uflow), .irq(irq)
  );

  tmr_freerun #(.W(FREE_W)) u_free (
    .clk(clk), .rst_n(rst_q_n), .fast_tick(fast_tick),
    .en_wr(wr_hi), .en_val(bus_wdata[FREE_EN_BIT]),
    .cnt(fr_cnt), .en(fr_en)
  );

  // Read mux
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_LOAD:    rd_mux = BUS_W'(load_q);
      REG_VALUE:   rd_mux = BUS_W'(tm_cnt);
      REG_CTRL: begin
        rd_mux[CTRL_RUN_BIT]  = ctrl_q.run;
        rd_mux[CTRL_PER_BIT]  = ctrl_q.periodic;
        rd_mux[CTRL_SLOW_BIT] = ctrl_q.slow_sel;
      end
      REG_FREE_LO: rd_mux = fr_cnt[BUS_W-1:0];
      REG_FREE_HI: begin
        rd_mux[HI_W-1:0]    = fr_cnt[FREE_W-1:BUS_W];
        rd_mux[FREE_EN_BIT] = fr_en;
      end
      default:     rd_mux = '0;
    endcase
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      load_q  <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      load_q  <= load_d;
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FREE_W = 40
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              fast_tick,
  input logic              irq,
  input logic              uflow,
  input logic              run,
  input logic              periodic,
  input logic [CNT_W-1:0]  tm_cnt,
  input logic [CNT_W-1:0]  load_q,
  input logic [FREE_W-1:0] fr_cnt
);
  assert_uflow_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    uflow |=> irq);

  assert_irq_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(irq) |-> $past(uflow));

  assert_clear_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && (bus_addr == REG_CLEAR) && !uflow) |=> !irq);

  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!run && !(bus_wr && (bus_addr == REG_CTRL))) |=> $stable(tm_cnt));

  assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (uflow && periodic) |=> (tm_cnt == $past(load_q)));

  assert_wrap_value_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (uflow && !periodic) |=> (tm_cnt == {CNT_W{1'b1}}));

  assert_free_idle_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !fast_tick |=> $stable(fr_cnt));
endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .fast_tick(fast_tick), .irq(irq), .uflow(tm_uflow),
  .run(ctrl_q.run), .periodic(ctrl_q.periodic),
  .tm_cnt(tm_cnt), .load_q(load_q), .fr_cnt(fr_cnt)
);

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_tick, fast_tick;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tmr_pair u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [2:0] A_LOAD = 3'd0, A_VAL = 3'd1, A_CTRL = 3'd2,
                         A_CLR = 3'd3, A_LO = 3'd4, A_HI = 3'd5;

  typedef struct packed {
    logic [15:0] ld;
    logic        per;
    logic [7:0]  nt;
    logic [15:0] ev;
    logic        ei;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'd5,      1'b1, 8'd3, 16'd2,      1'b0},
    '{16'd5,      1'b1, 8'd6, 16'd5,      1'b1},
    '{16'd5,      1'b1, 8'd8, 16'd3,      1'b1},
    '{16'd0,      1'b1, 8'd1, 16'd0,      1'b1},
    '{16'd0,      1'b1, 8'd0, 16'd0,      1'b0},
    '{16'd3,      1'b0, 8'd4, 16'hFFFF,   1'b1},
    '{16'd3,      1'b0, 8'd6, 16'hFFFD,   1'b1},
    '{16'hFFFF,   1'b1, 8'd2, 16'hFFFD,   1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic pulse_fast(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fast_tick = 1'b1;
      @(negedge clk); fast_tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; slow_tick = 1'b0; fast_tick = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reset read addr %0d", a), d, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    // R7 control masking and ignored count writes
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d);
    check("R7 control readback", d, 32'h0000_00C8);
    wr(A_CTRL, 32'h0);
    wr(A_VAL, 32'h1234);
    rd(A_VAL, d);
    check("R7 count write ignored", d, 32'h0);

    // R2 load only on run edge, hold while stopped
    wr(A_LOAD, 32'd7);
    wr(A_CTRL, 32'h48);
    pulse_slow(3);
    rd(A_VAL, d);
    check("R2 no load before run edge", d, 32'h0);
    wr(A_CTRL, 32'hC8);
    rd(A_VAL, d);
    check("R2 load on run edge", d, 32'd7);
    wr(A_CTRL, 32'h48);
    pulse_slow(2);
    wr(A_LOAD, 32'd9);
    rd(A_VAL, d);
    check("R2 hold while stopped", d, 32'd7);

    // R3 strobe selection
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'd10);
    wr(A_CTRL, 32'hC0);
    pulse_slow(2);
    rd(A_VAL, d);
    check("R3 unselected strobe ignored", d, 32'd10);
    pulse_fast(3);
    rd(A_VAL, d);
    check("R3 fast strobe decrements", d, 32'd7);
    wr(A_CTRL, 32'h0);
    wr(A_CLR, 32'h0);

    // R4 R5 R6 vector walk
    for (int k = 0; k < 8; k++) begin
      wr(A_CTRL, 32'h0);
      wr(A_CLR, 32'h0);
      wr(A_LOAD, {16'h0, VEC[k].ld});
      wr(A_CTRL, VEC[k].per ? 32'h48 : 32'h08);
      wr(A_CTRL, VEC[k].per ? 32'hC8 : 32'h88);
      pulse_slow(int'(VEC[k].nt));
      rd(A_VAL, d);
      check($sformatf("R4/R5 row %0d count (R4 R5)", k), d, {16'h0, VEC[k].ev});
      check($sformatf("R6 row %0d irq", k), {31'b0, irq}, {31'b0, VEC[k].ei});
    end

    // R6 underflow beats coincident clear, then clear works
    wr(A_CTRL, 32'h0);
    wr(A_CLR, 32'h0);
    wr(A_LOAD, 32'd0);
    wr(A_CTRL, 32'hC8);
    pulse_slow(1);
    repeat (3) @(negedge clk);
    check("R6 irq held", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h0);
    check("R6 clear drops irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    slow_tick = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'hA5;
    @(negedge clk);
    slow_tick = 1'b0; bus_wr = 1'b0;
    check("R6 underflow wins over clear", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    wr(A_CLR, 32'h0);

    // R8 R9 free-running counter
    pulse_fast(2);
    rd(A_LO, d);
    check("R8 disabled holds", d, 32'h0);
    wr(A_HI, 32'h100);
    rd(A_HI, d);
    check("R9 high word enable bit", d, 32'h100);
    pulse_fast(5);
    rd(A_LO, d);
    check("R8 counts fast strobes", d, 32'd5);
    check("R9 no irq from free counter", {31'b0, irq}, 32'h0);
    wr(A_HI, 32'h0);
    pulse_fast(3);
    rd(A_LO, d);
    check("R8 stopped holds", d, 32'd5);
    rd(A_HI, d);
    check("R9 high word after stop", d, 32'h0);

    // R10 read data holds without a read
    wr(A_LOAD, 32'h55);
    repeat (2) @(negedge clk);
    check("R10 rdata holds", bus_rdata, 32'h0);
    rd(A_LOAD, d);
    check("R10 read latency", d, 32'h55);

    // R1 reset during activity
    wr(A_CTRL, 32'hC8);
    wr(A_HI, 32'h100);
    pulse_fast(2);
    do_reset();
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 re-reset read addr %0d", a), d, 32'h0);
    end
    check("R1 re-reset irq", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule